// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits between the CPU's physical address path and the memory and PCI fabric and classifies every access that falls below 1 MB. For the option-ROM and BIOS area it consults a set of programmable two-bit attribute fields. Each field sends its region either to DRAM with full access, to DRAM with writes blocked, or out to the PCI bus. For the 128 KB graphics window at 0xA0000 it consults an SMRAM control byte together with a system-management-mode input. All other addresses are plain DRAM below a parameterised top of memory, and are reported as not decoded above it.

Software programs the attribute bytes and the SMRAM control byte through a byte-wide configuration port. The port stores a write on the clock edge and returns the stored byte combinationally. The decode itself is purely combinational from the access address, the write flag, the stored bytes and the mode input. A change of mode or of register contents therefore applies to the very next access with no pipeline delay.

The style asks for named states. This decoder keeps its state in configuration bytes, not a sequencer. Each address is sorted into one of four named regions. PLAIN covers ordinary DRAM or undecoded space. WINDOW is the graphics/SMRAM range. SEGMENT covers the twelve 16 KB option-ROM slices. TOPBIOS is the top 64 KB. The route returned is one of four named values: NONE, DRAM, DRAM_RO and PCI.

Top module: `lmd_decoder`

## Requirements
- R1: After reset every attribute byte (configuration offsets 0x59 to 0x5F) reads 0x00, the SMRAM control byte at offset 0x72 reads 0x02, and every legacy segment, the top BIOS range and the graphics window route to PCI.
- R2: A configuration write to offsets 0x59..0x5F or 0x72 is stored on the clock edge where cfg_we is high and read back combinationally on cfg_rdata. Any other offset reads 0x00, and a write to it changes no stored byte.
- R3: Addresses 0xF0000..0xFFFFF take their attribute from bits [5:4] of the byte at offset 0x59.
- R4: Segment i (0 to 11) covers 0xC0000+0x4000*i up to the next segment. It takes its attribute from bits [1:0] of the low nibble (bits [1:0]) of byte 0x5A+(i>>1) when i is even, and of its high nibble (bits [5:4]) when i is odd.
- R5: acc_route uses the codes 0=NONE, 1=DRAM, 2=DRAM_RO, 3=PCI. Attribute value 3 gives DRAM, 1 gives DRAM_RO, and 0 or 2 give PCI.
- R6: acc_wr_blocked is 1 exactly when acc_write is 1 and the access routes to DRAM_RO; reads of a read-only region are never blocked.
- R7: Addresses 0xA0000..0xBFFFF route to DRAM when (smm_active is 1 and bit 3 of byte 0x72 is 1) or bit 6 of byte 0x72 is 1. Otherwise they route to PCI.
- R8: A change of smm_active or of acc_addr is reflected on acc_route in the same cycle, with no clock edge needed.
- R9: Addresses below 0xA0000, and from 0x100000 up to TOP_OF_MEM-1, route to DRAM. Addresses at or above TOP_OF_MEM route to NONE.
- R10: Attribute byte bits outside the decoded two-bit fields (bits 3:2 and 7:6 of each byte, and bits 3:0 of byte 0x59) have no effect on the route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored byte at cfg_addr, 0 for unmapped offsets |
| smm_active | input | 1 | System-management mode is in effect |
| acc_addr | input | 32 | Physical address of the current access |
| acc_write | input | 1 | Current access is a write |
| acc_route | output | 2 | Route: 0 none, 1 DRAM, 2 DRAM read-only, 3 PCI |
| acc_wr_blocked | output | 1 | Current write targets a read-only region |

## Verification
The bench targets the nibble selection for odd and even segments. A decoder that swapped the nibbles, or used the wrong byte for a segment pair, would route a neighbouring slice's attribute and show up at segment start and end addresses. It also drives attribute values 0 and 2 and sets the unused bits in every byte. A design that treated value 2 as DRAM, or decoded a wider field, would send PCI traffic to memory. For the graphics window it walks every combination of the mode input and the two control bits, toggling the mode without a clock edge. This catches a design that ignored the mode qualifier or registered it. The top-of-memory and 1 MB boundaries are checked on both sides, to catch off-by-one comparisons that would claim undecoded space as DRAM.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [1:0] {
        RT_NONE    = 2'd0,
        RT_DRAM    = 2'd1,
        RT_DRAM_RO = 2'd2,
        RT_PCI     = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        RG_PLAIN   = 2'd0,
        RG_WINDOW  = 2'd1,
        RG_SEGMENT = 2'd2,
        RG_TOPBIOS = 2'd3
    } region_e;

    localparam logic [1:0] ATTR_RW = 2'd3;
    localparam logic [1:0] ATTR_RO = 2'd1;

    // Two-bit attribute to route; values 0 and 2 both forward to the bus.
    function automatic route_e attr_to_route(input logic [1:0] attr);
        route_e r;
        unique case (attr)
            ATTR_RW: r = RT_DRAM;
            ATTR_RO: r = RT_DRAM_RO;
            default: r = RT_PCI;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs #(
    parameter int unsigned          CFG_AW     = 8,
    parameter int unsigned          ATTR_BYTES = 7,
    parameter logic [CFG_AW-1:0]    ATTR_BASE  = 8'h59,
    parameter logic [CFG_AW-1:0]    SMRAM_OFF  = 8'h72,
    parameter logic [7:0]           SMRAM_RST  = 8'h02
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [7:0]                   cfg_wdata,
    output logic [7:0]                   cfg_rdata,
    output logic [ATTR_BYTES-1:0][7:0]   attr_bytes,
    output logic [7:0]                   smram_ctl
);

    logic [ATTR_BYTES-1:0] attr_hit;
    logic                  smram_hit;

    assign smram_hit = (cfg_addr == SMRAM_OFF);

    generate
        for (genvar k = 0; k < ATTR_BYTES; k++) begin : g_attr
            localparam logic [CFG_AW-1:0] OFF = CFG_AW'(ATTR_BASE + CFG_AW'(k));

            assign attr_hit[k] = (cfg_addr == OFF);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    attr_bytes[k] <= 8'h00;
                end else if (cfg_we && attr_hit[k]) begin
                    attr_bytes[k] <= cfg_wdata;
                end
            end

            // R2
            attr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && attr_hit[k]) |=> (attr_bytes[k] == $past(cfg_wdata)));

            // R2
            attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_we && attr_hit[k]) |=> $stable(attr_bytes[k]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_ctl <= SMRAM_RST;
        end else if (cfg_we && smram_hit) begin
            smram_ctl <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < ATTR_BYTES; k++) begin
            if (attr_hit[k]) cfg_rdata = attr_bytes[k];
        end
        if (smram_hit) cfg_rdata = smram_ctl;
    end

    // R2
    smram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && smram_hit) |=> $stable(smram_ctl));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_hit == '0 && !smram_hit) |-> (cfg_rdata == 8'h00));

endmodule

// File: rtl/lmd_region_decode.sv
module lmd_region_decode
    import lmd_pkg::*;
#(
    parameter int unsigned   ADDR_W     = 32,
    parameter int unsigned   SEG_COUNT  = 12,
    parameter int unsigned   SEG_SHIFT  = 14,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = 32'h0800_0000,
    localparam int unsigned  SIDX_W     = $clog2(SEG_COUNT)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [SIDX_W-1:0] seg_idx,
    output logic              below_tom
);

    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] SEG_BASE = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] SEG_END  = SEG_BASE + ADDR_W'(SEG_COUNT << SEG_SHIFT);
    localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(32'h0010_0000);

    logic [ADDR_W-1:0] seg_off;

    assign seg_off   = addr - SEG_BASE;
    assign seg_idx   = SIDX_W'(seg_off >> SEG_SHIFT);
    assign below_tom = (addr < TOP_OF_MEM);

    always_comb begin
        if (addr < WIN_BASE) begin
            region = RG_PLAIN;
        end else if (addr < SEG_BASE) begin
            region = RG_WINDOW;
        end else if (addr < SEG_END) begin
            region = RG_SEGMENT;
        end else if (addr < LOW_END) begin
            region = RG_TOPBIOS;
        end else begin
            region = RG_PLAIN;
        end
    end

endmodule

// File: rtl/lmd_attr_select.sv
module lmd_attr_select
    import lmd_pkg::*;
#(
    parameter int unsigned ATTR_BYTES = 7,
    parameter int unsigned SEG_COUNT  = 12,
    localparam int unsigned SIDX_W    = $clog2(SEG_COUNT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ATTR_BYTES-1:0][7:0]  attr_bytes,
    input  logic [7:0]                  smram_ctl,
    input  logic                        smm_active,
    input  region_e                     region,
    input  logic [SIDX_W-1:0]           seg_idx,
    input  logic                        below_tom,
    input  logic                        acc_write,
    output route_e                      route,
    output logic                        wr_blocked
);

    localparam int unsigned SMRAM_OPEN_BIT  = 6;
    localparam int unsigned SMRAM_SMM_BIT   = 3;
    localparam int unsigned TOPBIOS_LSB     = 4;

    logic [SEG_COUNT-1:0][1:0] seg_attr;
    logic [1:0]                top_attr;
    logic                      window_to_dram;

    // Even segments use the low nibble, odd segments the high nibble.
    generate
        for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
            localparam int unsigned BYTE_IX = 1 + (i / 2);
            localparam int unsigned LSB     = 4 * (i % 2);
            assign seg_attr[i] = attr_bytes[BYTE_IX][LSB +: 2];
        end
    endgenerate

    assign top_attr = attr_bytes[0][TOPBIOS_LSB +: 2];

    assign window_to_dram = (smm_active && smram_ctl[SMRAM_SMM_BIT])
                          || smram_ctl[SMRAM_OPEN_BIT];

    always_comb begin
        route = RT_NONE;
        unique case (region)
            RG_PLAIN: begin
                route = below_tom ? RT_DRAM : RT_NONE;
            end
            RG_WINDOW: begin
                route = window_to_dram ? RT_DRAM : RT_PCI;
            end
            RG_SEGMENT: begin
                if (32'(seg_idx) < SEG_COUNT) begin
                    route = attr_to_route(seg_attr[seg_idx]);
                end else begin
                    route = RT_PCI;
                end
            end
            RG_TOPBIOS: begin
                route = attr_to_route(top_attr);
            end
            default: route = RT_NONE;
        endcase
    end

    assign wr_blocked = acc_write && (route == RT_DRAM_RO);

    // R6
    blocked_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> acc_write);

    // R5
    ro_only_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_DRAM_RO) |-> (region == RG_SEGMENT || region == RG_TOPBIOS));

    // R7
    window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_WINDOW && smram_ctl[SMRAM_OPEN_BIT]) |-> (route == RT_DRAM));

    // R7
    window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_WINDOW && !smm_active && !smram_ctl[SMRAM_OPEN_BIT])
            |-> (route == RT_PCI));

    // R9
    above_tom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_PLAIN && !below_tom) |-> (route == RT_NONE));

endmodule

// File: rtl/lmd_decoder.sv
module lmd_decoder
    import lmd_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       CFG_AW     = 8,
    parameter int unsigned       SEG_COUNT  = 12,
    parameter int unsigned       SEG_SHIFT  = 14,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = 32'h0800_0000,
    parameter logic [CFG_AW-1:0] ATTR_BASE  = 8'h59,
    parameter logic [CFG_AW-1:0] SMRAM_OFF  = 8'h72,
    parameter logic [7:0]        SMRAM_RST  = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smm_active,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    output logic [1:0]        acc_route,
    output logic              acc_wr_blocked
);

    localparam int unsigned ATTR_BYTES = 1 + (SEG_COUNT + 1) / 2;
    localparam int unsigned SIDX_W     = $clog2(SEG_COUNT);

    logic [ATTR_BYTES-1:0][7:0] attr_bytes;
    logic [7:0]                 smram_ctl;
    region_e                    region;
    logic [SIDX_W-1:0]          seg_idx;
    logic                       below_tom;
    route_e                     route;

    lmd_cfg_regs #(
        .CFG_AW     (CFG_AW),
        .ATTR_BYTES (ATTR_BYTES),
        .ATTR_BASE  (ATTR_BASE),
        .SMRAM_OFF  (SMRAM_OFF),
        .SMRAM_RST  (SMRAM_RST)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (CFG_AW'(cfg_addr)),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .attr_bytes (attr_bytes),
        .smram_ctl  (smram_ctl)
    );

    lmd_region_decode #(
        .ADDR_W     (ADDR_W),
        .SEG_COUNT  (SEG_COUNT),
        .SEG_SHIFT  (SEG_SHIFT),
        .TOP_OF_MEM (TOP_OF_MEM)
    ) u_region (
        .addr       (ADDR_W'(acc_addr)),
        .region     (region),
        .seg_idx    (seg_idx),
        .below_tom  (below_tom)
    );

    lmd_attr_select #(
        .ATTR_BYTES (ATTR_BYTES),
        .SEG_COUNT  (SEG_COUNT)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .attr_bytes (attr_bytes),
        .smram_ctl  (smram_ctl),
        .smm_active (smm_active),
        .region     (region),
        .seg_idx    (seg_idx),
        .below_tom  (below_tom),
        .acc_write  (acc_write),
        .route      (route),
        .wr_blocked (acc_wr_blocked)
    );

    assign acc_route = route;

    // R1
    reset_route_chk: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> ((region == RG_SEGMENT || region == RG_TOPBIOS)
                                     ? (acc_route == 2'd3) : 1'b1));

    // R9
    low_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr < 32'h000A_0000) |-> (acc_route == 2'd1));

endmodule

// File: tb/test_lmd_decoder.sv
module test_lmd_decoder;

    localparam logic [31:0] TOM = 32'h0800_0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       smm_active = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_route;
    logic       acc_wr_blocked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench-side copy of what software has written.
    logic [7:0] mdl_attr [0:6];
    logic [7:0] mdl_smram;

    always #10 clk = ~clk;

    lmd_decoder #(.TOP_OF_MEM(TOM)) i_lmd_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .smm_active     (smm_active),
        .acc_addr       (acc_addr),
        .acc_write      (acc_write),
        .acc_route      (acc_route),
        .acc_wr_blocked (acc_wr_blocked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] attr_route(input logic [1:0] a);
        if (a == 2'd3) return 2'd1;
        if (a == 2'd1) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] exp_route(input logic [31:0] a);
        if (a < 32'h000A_0000) return 2'd1;
        if (a < 32'h000C_0000)
            return ((smm_active && mdl_smram[3]) || mdl_smram[6]) ? 2'd1 : 2'd3;
        if (a < 32'h000F_0000) begin
            int i = int'((a - 32'h000C_0000) >> 14);
            logic [7:0] b = mdl_attr[1 + i / 2];
            return attr_route((i % 2 == 1) ? b[5:4] : b[1:0]);
        end
        if (a < 32'h0010_0000) return attr_route(mdl_attr[0][5:4]);
        if (a < TOM) return 2'd1;
        return 2'd0;
    endfunction

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (off >= 8'h59 && off <= 8'h5F) mdl_attr[off - 8'h59] = val;
        if (off == 8'h72) mdl_smram = val;
    endtask

    task automatic cfg_read_check(input string req, input logic [7:0] off, input logic [7:0] exp);
        cfg_addr = off;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic access_check(input string req, input logic [31:0] a, input logic wr);
        logic [1:0] er;
        acc_addr = a; acc_write = wr;
        #1;
        er = exp_route(a);
        check(req, {30'h0, acc_route}, {30'h0, er});
        check({req, " blocked"}, {31'h0, acc_wr_blocked}, {31'h0, (wr && er == 2'd2)});
    endtask

    task automatic test_reset;
        for (int k = 0; k < 7; k++) cfg_read_check("R1 attr reset", 8'(8'h59 + k), 8'h00);
        cfg_read_check("R1 smram reset", 8'h72, 8'h02);
        access_check("R1 seg0 pci", 32'h000C_0000, 1'b0);
        access_check("R1 seg11 pci", 32'h000E_FFFF, 1'b0);
        access_check("R1 top bios pci", 32'h000F_0000, 1'b0);
        access_check("R1 window pci", 32'h000A_0000, 1'b0);
        check("R1 window route code", {30'h0, acc_route}, 32'd3);
    endtask

    task automatic test_cfg_port;
        cfg_write(8'h5C, 8'hA5);
        cfg_read_check("R2 readback 5C", 8'h5C, 8'hA5);
        cfg_write(8'h60, 8'hFF);
        cfg_read_check("R2 unmapped 60", 8'h60, 8'h00);
        cfg_write(8'h58, 8'hFF);
        cfg_read_check("R2 unmapped 58", 8'h58, 8'h00);
        cfg_read_check("R2 5F untouched", 8'h5F, 8'h00);
        cfg_read_check("R2 59 untouched", 8'h59, 8'h00);
        cfg_read_check("R2 smram untouched", 8'h72, 8'h02);
        cfg_write(8'h5C, 8'h00);
    endtask

    task automatic test_top_bios;
        cfg_write(8'h59, 8'h30);
        access_check("R3 top rw", 32'h000F_8000, 1'b1);
        check("R5 top rw code", {30'h0, acc_route}, 32'd1);
        cfg_write(8'h59, 8'h10);
        access_check("R3 top ro read", 32'h000F_0000, 1'b0);
        access_check("R6 top ro write", 32'h000F_FFFF, 1'b1);
        check("R6 blocked set", {31'h0, acc_wr_blocked}, 32'd1);
        cfg_write(8'h59, 8'h20);
        access_check("R5 top attr2 pci", 32'h000F_1234, 1'b1);
        cfg_write(8'h59, 8'hCF);
        access_check("R10 top unused bits", 32'h000F_0000, 1'b0);
        check("R10 top pci", {30'h0, acc_route}, 32'd3);
    endtask

    task automatic test_segments;
        logic [7:0] pat [0:5];
        pat[0] = 8'h13; pat[1] = 8'h31; pat[2] = 8'h20;
        pat[3] = 8'h03; pat[4] = 8'h12; pat[5] = 8'h30;
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] v = (p == 0) ? pat[k] : pat[5 - k];
                if (p == 1) v = v | 8'hCC;  // unused bits set
                cfg_write(8'(8'h5A + k), v);
            end
            for (int i = 0; i < 12; i++) begin
                logic [31:0] base = 32'h000C_0000 + 32'(i) * 32'h4000;
                access_check((p == 0) ? "R4 seg start" : "R10 seg start", base, 1'b0);
                access_check((p == 0) ? "R4 seg end" : "R10 seg end", base + 32'h3FFF, 1'b1);
            end
        end
    endtask

    task automatic test_write_block;
        cfg_write(8'h5A, 8'h31);
        access_check("R6 ro read", 32'h000C_0010, 1'b0);
        check("R6 ro read not blocked", {31'h0, acc_wr_blocked}, 32'd0);
        access_check("R6 ro write", 32'h000C_0010, 1'b1);
        access_check("R6 rw write", 32'h000C_4010, 1'b1);
        check("R6 rw not blocked", {31'h0, acc_wr_blocked}, 32'd0);
    endtask

    task automatic test_window;
        for (int c = 0; c < 8; c++) begin
            logic [7:0] v = 8'h02 | ((c & 1) ? 8'h08 : 8'h00) | ((c & 2) ? 8'h40 : 8'h00);
            cfg_write(8'h72, v);
            smm_active = (c & 4) != 0;
            access_check("R7 window", 32'h000B_FFFF, 1'b1);
        end
        cfg_write(8'h72, 8'h0A);
        @(negedge clk);
        smm_active = 1'b0;
        access_check("R8 smm low", 32'h000A_8000, 1'b0);
        #3 smm_active = 1'b1;
        access_check("R8 smm high", 32'h000A_8000, 1'b0);
        check("R8 immediate dram", {30'h0, acc_route}, 32'd1);
        #3 smm_active = 1'b0;
        access_check("R8 smm drop", 32'h000A_8000, 1'b0);
        check("R8 immediate pci", {30'h0, acc_route}, 32'd3);
    endtask

    task automatic test_plain;
        access_check("R9 zero", 32'h0000_0000, 1'b1);
        access_check("R9 below window", 32'h0009_FFFF, 1'b1);
        access_check("R9 one mb", 32'h0010_0000, 1'b1);
        access_check("R9 tom-1", TOM - 32'h1, 1'b0);
        access_check("R9 tom", TOM, 1'b1);
        check("R9 tom none", {30'h0, acc_route}, 32'd0);
        access_check("R9 high", 32'hFFFF_FFF0, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 7; k++) mdl_attr[k] = 8'h00;
        mdl_smram = 8'h02;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_cfg_port();
        test_top_bios();
        test_segments();
        test_write_block();
        test_window();
        test_plain();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule